// File: doc/BRIEF.md
# Receive FIFO with Threshold Interrupt

This block buffers received characters for a serial port. Each entry holds an 8-bit character and a 3-bit error tag from the receiver. The tag bits flag a parity error, a framing error and a break. The FIFO holds up to 128 entries. A host read strobe pops the oldest entry into a registered output pair.

The block raises a receive-data interrupt when the number of stored entries reaches a threshold chosen by a 2-bit select. It drops the interrupt again once the count falls below that threshold. A status bit follows the same condition, so a host can see it without taking the interrupt. When the interrupt enable is low, the block runs in polled mode: the interrupt line stays low and all status outputs keep updating.

The block also produces two line-status flags. Data ready is high while any entry is stored. A summary error flag is high while any stored entry carries a nonzero tag.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, `data_ready`, `err_any`, `rx_stat`, `irq` and the outputs `rd_data` and `rd_tag` are all 0.
- R2: Entries leave in the order they were accepted. A strobe on `rd_stb` while the FIFO is not empty places the oldest entry on `rd_data`/`rd_tag` after the next rising clock edge.
- R3: The FIFO holds at most 128 entries. A write to a full FIFO without a read in the same cycle is discarded and does not change the stored contents.
- R4: `data_ready` is 1 exactly while at least one entry is stored.
- R5: With `fifo_on`=1, `trig_sel` picks the threshold: 0 picks 1, 1 picks 32, 2 picks 64, 3 picks 112. `rx_stat` is 1 exactly while the stored count is greater than or equal to that threshold.
- R6: `irq` equals `rx_stat` when `rx_ie`=1. When `rx_ie`=0 (polled mode), `irq` stays 0 while `rx_stat`, `data_ready` and `err_any` keep updating.
- R7: With `fifo_on`=0, the threshold is 1 whatever the value of `trig_sel`.
- R8: `err_any` is 1 exactly while at least one stored entry has a nonzero tag. It falls when the last such entry is read out.
- R9: A write and a read in the same cycle on a non-empty FIFO leave the count unchanged. A read strobe on an empty FIFO leaves `rd_data`, `rd_tag` and all status outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | FIFO mode enable; 0 forces a threshold of 1 |
| rx_ie | input | 1 | Receive-data interrupt enable |
| trig_sel | input | 2 | Threshold select |
| wr_en | input | 1 | Receiver writes an entry |
| wr_data | input | 8 | Received character |
| wr_tag | input | 3 | Error tag of the character (parity, framing, break) |
| rd_stb | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Character of the last popped entry |
| rd_tag | output | 3 | Tag of the last popped entry |
| data_ready | output | 1 | At least one entry stored |
| err_any | output | 1 | Some stored entry carries an error |
| rx_stat | output | 1 | Interrupt-status bit for the threshold condition |
| irq | output | 1 | Receive-data interrupt line |

## Verification
The bench steps the count across each threshold boundary: one below, equal, and back down. A comparator that is off by one would assert too early or release too late. It fills the FIFO to 128 and keeps writing, then drains it. A design that wraps or overwrites on a full write would show up as a wrong or extra character. The bench reads the last tagged entry out while clean entries stay stored, which catches an error flag that clears on the wrong pop or clears only when the FIFO is empty. It also applies reads to an empty FIFO and paired read-writes at the full and empty limits, where a wrong pointer or count update would corrupt the held output or the fill level.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
// Entry storage: circular buffer with a registered pop output.
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  rxf_entry_t wr_entry,
  output rxf_entry_t head,
  output rxf_entry_t rd_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rxf_entry_t        mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     rptr_q, rptr_d;
  rxf_entry_t        rd_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    rd_d   = rd_q;
    if (push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop) begin
      rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      rd_d   = mem[rptr_q];
    end
  end

  assign head = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      rd_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/rxf_level.sv
// Fill count and count of error-tagged entries.
module rxf_level #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          push_bad,
  input  logic          pop_bad,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] bad_cnt
);
  logic [CW-1:0] occ_d, bad_d;

  always_comb begin
    occ_d = occ;
    bad_d = bad_cnt;
    unique case ({push, pop})
      2'b10:   occ_d = occ + 1'b1;
      2'b01:   occ_d = occ - 1'b1;
      default: occ_d = occ;
    endcase
    unique case ({push_bad, pop_bad})
      2'b10:   bad_d = bad_cnt + 1'b1;
      2'b01:   bad_d = bad_cnt - 1'b1;
      default: bad_d = bad_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= '0;
      bad_cnt <= '0;
    end else begin
      occ     <= occ_d;
      bad_cnt <= bad_d;
    end
  end
endmodule

// File: rtl/rxf_irq.sv
// Threshold compare for the interrupt-status bit and interrupt line.
module rxf_irq #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          fifo_on,
  input  logic          rx_ie,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] occ,
  output logic          rx_stat,
  output logic          irq
);
  localparam int NLVL = 4;
  localparam int LVL_NUM [NLVL] = '{1, 0, 0, 0};
  logic [CW-1:0] lvl_tab [NLVL];
  logic [CW-1:0] thr;

  generate
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
      if (i == 0) begin : g_one
        assign lvl_tab[i] = CW'(LVL_NUM[0]);
      end else if (i == NLVL - 1) begin : g_top
        assign lvl_tab[i] = CW'((DEPTH * 7) / 8);
      end else begin : g_mid
        assign lvl_tab[i] = CW'((DEPTH * i) / 4);
      end
    end
  endgenerate

  always_comb begin
    thr = fifo_on ? lvl_tab[trig_sel] : lvl_tab[0];
  end

  assign rx_stat = (occ >= thr);
  assign irq     = rx_stat & rx_ie;
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxf_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_on,
  input  logic              rx_ie,
  input  logic [1:0]        trig_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              data_ready,
  output logic              err_any,
  output logic              rx_stat,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ, bad_cnt;
  logic          push, pop, push_bad, pop_bad;
  rxf_entry_t    wr_entry, head, rd_q;

  assign wr_entry = '{tag: wr_tag, data: wr_data};
  assign pop      = rd_stb && (occ != '0);
  assign push     = wr_en && ((occ < CW'(DEPTH)) || pop);
  assign push_bad = push && (wr_tag != '0);
  assign pop_bad  = pop && (head.tag != '0);

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_entry(wr_entry), .head(head), .rd_q(rd_q)
  );

  rxf_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_bad(push_bad), .pop_bad(pop_bad), .occ(occ), .bad_cnt(bad_cnt)
  );

  rxf_irq #(.DEPTH(DEPTH), .CW(CW)) u_irq (
    .fifo_on(fifo_on), .rx_ie(rx_ie), .trig_sel(trig_sel), .occ(occ),
    .rx_stat(rx_stat), .irq(irq)
  );

  assign rd_data    = rd_q.data;
  assign rd_tag     = rd_q.tag;
  assign data_ready = (occ != '0);
  assign err_any    = (bad_cnt != '0);
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_on,
  input logic          rx_ie,
  input logic [1:0]    trig_sel,
  input logic          wr_en,
  input logic          rd_stb,
  input logic [7:0]    rd_data,
  input logic          data_ready,
  input logic          err_any,
  input logic          rx_stat,
  input logic          irq,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] bad_cnt
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_stb && occ == CW'(DEPTH)) |=> (occ == CW'(DEPTH)));

  p_bad_le_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= occ);

  p_err_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> data_ready);

  p_polled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq);

  p_irq_has_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rx_stat);

  p_level_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && trig_sel == 2'd0 && data_ready) |-> rx_stat);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_ready) |=> $stable(rd_data));

  p_pair_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_stb && data_ready) |=> $stable(occ));
endmodule

bind rx_fifo_trig rxf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .rx_ie(rx_ie),
  .trig_sel(trig_sel), .wr_en(wr_en), .rd_stb(rd_stb), .rd_data(rd_data),
  .data_ready(data_ready), .err_any(err_any), .rx_stat(rx_stat), .irq(irq),
  .occ(occ), .bad_cnt(bad_cnt)
);

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
  localparam int DEPTH = 128;

  logic       clk, rst_n;
  logic       fifo_on, rx_ie, wr_en, rd_stb;
  logic [1:0] trig_sel;
  logic [7:0] wr_data, rd_data;
  logic [2:0] wr_tag, rd_tag;
  logic       data_ready, err_any, rx_stat, irq;

  int checks = 0;
  int errors = 0;
  logic [10:0] q[$];
  logic [7:0]  exp_rd;
  logic [2:0]  exp_tag;

  rx_fifo_trig #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .rx_ie(rx_ie),
    .trig_sel(trig_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_tag(rd_tag),
    .data_ready(data_ready), .err_any(err_any), .rx_stat(rx_stat), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int level_of(logic en, logic [1:0] sel);
    if (!en) return 1;
    case (sel)
      2'd0: return 1;
      2'd1: return 32;
      2'd2: return 64;
      default: return 112;
    endcase
  endfunction

  function automatic int bad_in_q();
    int n = 0;
    foreach (q[i]) if (q[i][10:8] != 3'd0) n++;
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_status();
    logic st;
    st = (q.size() >= level_of(fifo_on, trig_sel));
    chk("R4 data_ready", data_ready, q.size() > 0);
    chk("R5/R7 rx_stat", rx_stat, st);
    chk("R6 irq", irq, st & rx_ie);
    chk("R8 err_any", err_any, bad_in_q() > 0);
  endtask

  // apply one cycle; model updates; sample 1ns after edge
  task automatic cyc(logic w, logic [7:0] d, logic [2:0] t, logic r);
    logic did_pop;
    wr_en = w; wr_data = d; wr_tag = t; rd_stb = r;
    did_pop = r && (q.size() > 0);
    @(posedge clk); #1;
    if (did_pop) begin
      {exp_tag, exp_rd} = q.pop_front();
    end
    if (w && (q.size() < DEPTH || did_pop)) q.push_back({t, d});
    wr_en = 0; rd_stb = 0;
    chk("R2 rd_data", rd_data, exp_rd);
    chk("R2 rd_tag", rd_tag, exp_tag);
    check_status();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; fifo_on = 1; rx_ie = 1; trig_sel = 0;
    wr_en = 0; rd_stb = 0; wr_data = 0; wr_tag = 0;
    exp_rd = 0; exp_tag = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rd_tag", rd_tag, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 err_any", err_any, 0);
    chk("R1 rx_stat", rx_stat, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R9 read from empty holds everything
    cyc(0, 0, 0, 1);
    // R5 threshold 1 then R2 single pass
    cyc(1, 8'hA5, 0, 0);
    chk("R5 level1 stat", rx_stat, 1);
    cyc(0, 0, 0, 1);
    chk("R2 first byte", rd_data, 8'hA5);
    cyc(0, 0, 0, 1); // R9 empty read keeps A5
    chk("R9 held value", rd_data, 8'hA5);

    // R5 boundary at 32, R6 polled mode
    trig_sel = 2'd1;
    for (int i = 0; i < 31; i++) cyc(1, 8'(i), 0, 0);
    chk("R5 below 32", rx_stat, 0);
    cyc(1, 8'd31, 0, 0);
    chk("R5 at 32", rx_stat, 1);
    chk("R6 irq at 32", irq, 1);
    rx_ie = 0; #1;
    check_status();
    chk("R6 polled irq low", irq, 0);
    rx_ie = 1;
    cyc(0, 0, 0, 1);
    chk("R5 back below 32", rx_stat, 0);
    // R7 fifo off forces level 1
    fifo_on = 0; trig_sel = 2'd3; #1;
    check_status();
    chk("R7 fifo off stat", rx_stat, 1);
    fifo_on = 1; #1;
    check_status();

    // R3 fill to full, write beyond, pair at full
    trig_sel = 2'd3;
    while (q.size() < DEPTH) cyc(1, 8'($urandom), 0, 0);
    cyc(1, 8'hEE, 3'd1, 0);
    cyc(1, 8'hEF, 3'd2, 0);
    chk("R3 full no error", err_any, 0);
    cyc(1, 8'h77, 3'd4, 1); // R9 pair at full
    chk("R9 pair keeps full", data_ready, 1);
    while (q.size() > 0) cyc(0, 0, 0, 1);
    chk("R3 drained", data_ready, 0);
    chk("R3 last is paired write", rd_data, 8'h77);

    // R8 last bad entry leaves while clean ones remain
    trig_sel = 2'd0;
    cyc(1, 8'h10, 3'd2, 0);
    cyc(1, 8'h11, 3'd0, 0);
    cyc(1, 8'h12, 3'd0, 0);
    chk("R8 flag set", err_any, 1);
    cyc(0, 0, 0, 1);
    chk("R8 cleared on bad read", err_any, 0);
    chk("R8 still data", data_ready, 1);
    while (q.size() > 0) cyc(0, 0, 0, 1);

    // random mixed traffic, all paths
    for (int ph = 0; ph < 8; ph++) begin
      int wp = (ph % 2 == 0) ? 75 : 30;
      trig_sel = 2'($urandom);
      fifo_on = ($urandom % 5) != 0;
      rx_ie = ($urandom % 3) != 0;
      for (int i = 0; i < 700; i++) begin
        cyc(($urandom % 100) < wp, 8'($urandom),
            (($urandom % 6) == 0) ? 3'($urandom) : 3'd0,
            ($urandom % 100) < (100 - wp));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule